// File: doc/BRIEF.md
# Banked Data Address Generator

This block turns the address fields of a data-memory access into one physical byte address for a 512-entry data store. A direct access joins a two-bit bank number to a seven-bit offset. An access to offset zero of any bank is not a real location. It is redirected through an eight-bit pointer, and an extra bank bit is placed above that pointer.

Two address corrections are applied to the resulting address. The upper sixteen offsets of every bank (70h..7Fh within the bank) are one shared region, and all of them resolve to bank 0. An indirect access whose pointer selects offset zero of any bank would point back at the redirect location. Such an access is nulled: the read is marked to return 00h and any write is dropped. The block also flags addresses in the lowest 32 offsets of a bank, so that an external register decoder can claim them.

The address, read enable and flags are combinational. The write is registered: the address and the write strobe reach the memory one clock after the request, taken from the pointer and bank values present in the request cycle.

Top module: `bank_addr_gen`

## Requirements
- R1: When `dir_addr` is not zero, `mem_addr` equals {`bank_sel`, `dir_addr`} (bank_sel in bits 8:7), unless R4 folds it.
- R2: When `dir_addr` is zero, `is_indirect` is 1 and `mem_addr` equals {`ind_bank`, `ptr`} (ind_bank in bit 8), unless R4 folds it.
- R3: An indirect access whose address has bits 6:0 equal to zero is null. `mem_rd_en` is 0, `rd_force_zero` equals `req_rd`, `is_special` is 0, and a write request produces no `wr_en`.
- R4: Any formed address whose bits 6:0 lie in 70h..7Fh is output with bits 8:7 cleared, so it lands in 070h..07Fh. This holds for direct and indirect accesses alike.
- R5: `is_special` is 1 exactly when the access is not null and bits 6:0 of `mem_addr` are below 20h.
- R6: A non-null write request in one cycle gives `wr_en` = 1 in the next cycle, with `wr_addr` equal to that request's `mem_addr`. Without such a request, `wr_en` is 0 in the next cycle.
- R7: While `rst_n` is low, `wr_en` is 0 and `wr_addr` is 0, whatever the request inputs are.
- R8: `mem_rd_en` is 1 only while `req_rd` is 1 and the access is not null. When `req_rd` is 0, `rd_force_zero` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_rd | input | 1 | Read request this cycle |
| req_wr | input | 1 | Write request this cycle |
| dir_addr | input | 7 | Offset field of the direct address |
| bank_sel | input | 2 | Bank number for direct access |
| ptr | input | 8 | Indirect pointer |
| ind_bank | input | 1 | Bank-pair bit for indirect access |
| mem_addr | output | 9 | Physical address, combinational |
| mem_rd_en | output | 1 | Read enable toward memory |
| rd_force_zero | output | 1 | Read data must be forced to 00h |
| is_special | output | 1 | Address lies in the register range of its bank |
| is_indirect | output | 1 | Access went through the pointer |
| wr_addr | output | 9 | Registered write address |
| wr_en | output | 1 | Registered write strobe |

## Verification
The assertions assume that a read and a write are never requested in the same cycle. The stimulus table and the directed tests respect this: each step raises at most one request. The write checks assume the address fields stay stable from the falling edge until the next rising edge. The bench therefore changes its inputs only on falling edges, and it observes the registered write one edge later.

// File: rtl/bank_addr_gen_pkg.sv
package bank_addr_gen_pkg;
    localparam int DIR_W     = 7;
    localparam int BANK_W    = 2;
    localparam int PTR_W     = 8;
    localparam int PHYS_W    = BANK_W + DIR_W;
    localparam int COMMON_LO = 'h70;
    localparam int SPECIAL_N = 32;

    typedef struct packed {
        logic              wr_en;
        logic [PHYS_W-1:0] wr_addr;
    } wr_state_t;
endpackage

// File: rtl/bag_form.sv
module bag_form #(
    parameter int DIR_W  = 7,
    parameter int BANK_W = 2,
    parameter int PTR_W  = 8,
    localparam int PHYS_W = BANK_W + DIR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIR_W-1:0]  dir_addr,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [PTR_W-1:0]  ptr,
    input  logic              ind_bank,
    output logic [PHYS_W-1:0] eff_addr,
    output logic              indirect
);
    always_comb begin
        indirect = (dir_addr == '0);
        if (indirect) begin
            eff_addr = {ind_bank, ptr};
        end else begin
            eff_addr = {bank_sel, dir_addr};
        end
    end

    AST_INDIRECT_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        indirect |-> (eff_addr[PTR_W-1:0] == ptr)); // R2
    AST_DIRECT_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        !indirect |-> (eff_addr[PHYS_W-1:DIR_W] == bank_sel)); // R1
endmodule

// File: rtl/bag_fold.sv
module bag_fold #(
    parameter int  DIR_W     = 7,
    parameter int  BANK_W    = 2,
    parameter int  COMMON_LO = 'h70,
    parameter int  SPECIAL_N = 32,
    parameter bit  FOLD_EN   = 1'b1,
    localparam int PHYS_W    = BANK_W + DIR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PHYS_W-1:0] eff_addr,
    input  logic              indirect,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              null_hit,
    output logic              special_hit
);
    logic [DIR_W-1:0] offset;
    assign offset = eff_addr[DIR_W-1:0];

    generate
        if (FOLD_EN) begin : g_fold
            always_comb begin
                if (offset >= DIR_W'(COMMON_LO)) begin
                    phys_addr = {{BANK_W{1'b0}}, offset};
                end else begin
                    phys_addr = eff_addr;
                end
            end
        end else begin : g_nofold
            assign phys_addr = eff_addr;
        end
    endgenerate

    always_comb begin
        null_hit    = indirect && (offset == '0);
        special_hit = !null_hit && (offset < DIR_W'(SPECIAL_N));
    end

    AST_COMMON_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (FOLD_EN && phys_addr[DIR_W-1:0] >= DIR_W'(COMMON_LO))
            |-> (phys_addr[PHYS_W-1:DIR_W] == '0)); // R4
    AST_SPECIAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        special_hit |-> (phys_addr[DIR_W-1:0] < DIR_W'(SPECIAL_N))); // R5
    AST_NULL_ONLY_INDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        null_hit |-> (indirect && !special_hit)); // R3
endmodule

// File: rtl/bank_addr_gen.sv
module bank_addr_gen
    import bank_addr_gen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [DIR_W-1:0]  dir_addr,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic [PTR_W-1:0]  ptr,
    input  logic              ind_bank,
    output logic [PHYS_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              rd_force_zero,
    output logic              is_special,
    output logic              is_indirect,
    output logic [PHYS_W-1:0] wr_addr,
    output logic              wr_en
);
    logic [PHYS_W-1:0] eff_addr;
    logic              indirect;
    logic [PHYS_W-1:0] phys_addr;
    logic              null_hit;
    logic              special_hit;
    wr_state_t         st_d;
    wr_state_t         st_q;

    bag_form #(
        .DIR_W (DIR_W),
        .BANK_W(BANK_W),
        .PTR_W (PTR_W)
    ) form_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir_addr(dir_addr),
        .bank_sel(bank_sel),
        .ptr     (ptr),
        .ind_bank(ind_bank),
        .eff_addr(eff_addr),
        .indirect(indirect)
    );

    bag_fold #(
        .DIR_W    (DIR_W),
        .BANK_W   (BANK_W),
        .COMMON_LO(COMMON_LO),
        .SPECIAL_N(SPECIAL_N),
        .FOLD_EN  (1'b1)
    ) fold_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .eff_addr   (eff_addr),
        .indirect   (indirect),
        .phys_addr  (phys_addr),
        .null_hit   (null_hit),
        .special_hit(special_hit)
    );

    always_comb begin
        st_d         = st_q;
        st_d.wr_en   = req_wr && !null_hit;
        st_d.wr_addr = st_d.wr_en ? phys_addr : st_q.wr_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr      = phys_addr;
    assign mem_rd_en     = req_rd && !null_hit;
    assign rd_force_zero = req_rd && null_hit;
    assign is_special    = special_hit;
    assign is_indirect   = indirect;
    assign wr_addr       = st_q.wr_addr;
    assign wr_en         = st_q.wr_en;

    AST_WRITE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && !null_hit) |=> (wr_en && wr_addr == $past(mem_addr))); // R6
    AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_wr && !null_hit) |=> !wr_en); // R6
    AST_NULL_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_force_zero |-> (!mem_rd_en && is_indirect)); // R3
    AST_RD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en || rd_force_zero) |-> req_rd); // R8
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_rd && req_wr)); // R8
endmodule

// File: tb/bank_addr_gen_tb_top.sv
module bank_addr_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_rd = 1'b0;
    logic       req_wr = 1'b0;
    logic [6:0] dir_addr = '0;
    logic [1:0] bank_sel = '0;
    logic [7:0] ptr = '0;
    logic       ind_bank = 1'b0;
    logic [8:0] mem_addr;
    logic       mem_rd_en;
    logic       rd_force_zero;
    logic       is_special;
    logic       is_indirect;
    logic [8:0] wr_addr;
    logic       wr_en;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    bank_addr_gen dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_rd       (req_rd),
        .req_wr       (req_wr),
        .dir_addr     (dir_addr),
        .bank_sel     (bank_sel),
        .ptr          (ptr),
        .ind_bank     (ind_bank),
        .mem_addr     (mem_addr),
        .mem_rd_en    (mem_rd_en),
        .rd_force_zero(rd_force_zero),
        .is_special   (is_special),
        .is_indirect  (is_indirect),
        .wr_addr      (wr_addr),
        .wr_en        (wr_en)
    );

    typedef struct packed {
        logic       rd;
        logic       wr;
        logic [6:0] dir;
        logic [1:0] bank;
        logic [7:0] p;
        logic       ib;
        logic [8:0] e_addr;
        logic       e_rd_en;
        logic       e_zero;
        logic       e_spec;
        logic       e_ind;
        logic       e_wr;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,7'h25,2'd2,8'h00,1'b0,9'h125,1'b1,1'b0,1'b0,1'b0,1'b0}, // R1 bank 2 direct
        '{1'b1,1'b0,7'h05,2'd1,8'h00,1'b0,9'h085,1'b1,1'b0,1'b1,1'b0,1'b0}, // R5 special in bank 1
        '{1'b1,1'b0,7'h00,2'd0,8'h44,1'b1,9'h144,1'b1,1'b0,1'b0,1'b1,1'b0}, // R2 indirect upper pair
        '{1'b1,1'b0,7'h00,2'd3,8'h00,1'b0,9'h000,1'b0,1'b1,1'b0,1'b1,1'b0}, // R3 self reference
        '{1'b1,1'b0,7'h00,2'd0,8'h80,1'b1,9'h180,1'b0,1'b1,1'b0,1'b1,1'b0}, // R3 self reference bank 3
        '{1'b1,1'b0,7'h7A,2'd3,8'h00,1'b0,9'h07A,1'b1,1'b0,1'b0,1'b0,1'b0}, // R4 fold direct
        '{1'b1,1'b0,7'h00,2'd2,8'hF3,1'b0,9'h073,1'b1,1'b0,1'b0,1'b1,1'b0}, // R4 fold indirect
        '{1'b1,1'b0,7'h1F,2'd0,8'h00,1'b0,9'h01F,1'b1,1'b0,1'b1,1'b0,1'b0}, // R5 last special
        '{1'b1,1'b0,7'h20,2'd1,8'h00,1'b0,9'h0A0,1'b1,1'b0,1'b0,1'b0,1'b0}, // R5 first general
        '{1'b1,1'b0,7'h6F,2'd2,8'h00,1'b0,9'h16F,1'b1,1'b0,1'b0,1'b0,1'b0}, // R4 just below fold
        '{1'b0,1'b0,7'h30,2'd0,8'h00,1'b0,9'h030,1'b0,1'b0,1'b0,1'b0,1'b0}, // R8 idle
        '{1'b0,1'b1,7'h00,2'd1,8'h00,1'b0,9'h000,1'b0,1'b0,1'b0,1'b1,1'b0}, // R3 null write
        '{1'b0,1'b1,7'h55,2'd1,8'h00,1'b0,9'h0D5,1'b0,1'b0,1'b0,1'b0,1'b1}, // R6 write
        '{1'b0,1'b1,7'h00,2'd0,8'hFF,1'b1,9'h07F,1'b0,1'b0,1'b0,1'b1,1'b1}  // R6 R4 folded write
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic rd, input logic wr, input logic [6:0] d,
                         input logic [1:0] b, input logic [7:0] p, input logic ib);
        req_rd   = rd;
        req_wr   = wr;
        dir_addr = d;
        bank_sel = b;
        ptr      = p;
        ind_bank = ib;
    endtask

    initial begin
        #400000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // R7: reset holds write path idle with a live write request
        drive(1'b0, 1'b1, 7'h40, 2'd1, 8'h00, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        check("R7 wr_en in reset", 32'(wr_en), 32'd0);
        check("R7 wr_addr in reset", 32'(wr_addr), 32'd0);
        @(negedge clk);
        drive(1'b0, 1'b0, 7'h40, 2'd1, 8'h00, 1'b0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R7 wr_en after reset idle", 32'(wr_en), 32'd0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i].rd, VECS[i].wr, VECS[i].dir, VECS[i].bank, VECS[i].p, VECS[i].ib);
            #1;
            check("R1 R2 R4 mem_addr", 32'(mem_addr), 32'(VECS[i].e_addr));
            check("R8 R3 mem_rd_en", 32'(mem_rd_en), 32'(VECS[i].e_rd_en));
            check("R3 rd_force_zero", 32'(rd_force_zero), 32'(VECS[i].e_zero));
            check("R5 is_special", 32'(is_special), 32'(VECS[i].e_spec));
            check("R2 is_indirect", 32'(is_indirect), 32'(VECS[i].e_ind));
            @(posedge clk);
            #1;
            check("R6 R3 wr_en", 32'(wr_en), 32'(VECS[i].e_wr));
            if (VECS[i].e_wr) check("R6 wr_addr", 32'(wr_addr), 32'(VECS[i].e_addr));
        end

        // R6: back-to-back writes, then idle drops the strobe
        @(negedge clk);
        drive(1'b0, 1'b1, 7'h21, 2'd3, 8'h00, 1'b0);
        @(posedge clk);
        #1;
        check("R6 b2b first wr_en", 32'(wr_en), 32'd1);
        check("R6 b2b first wr_addr", 32'(wr_addr), 32'h1A1);
        @(negedge clk);
        drive(1'b0, 1'b1, 7'h00, 2'd0, 8'h2B, 1'b0);
        @(posedge clk);
        #1;
        check("R6 b2b second wr_addr", 32'(wr_addr), 32'h02B);
        @(negedge clk);
        drive(1'b1, 1'b0, 7'h10, 2'd0, 8'h00, 1'b0);
        @(posedge clk);
        #1;
        check("R6 strobe drops on read", 32'(wr_en), 32'd0);

        // R7: reset asserted mid-run clears the registered write
        @(negedge clk);
        drive(1'b0, 1'b1, 7'h33, 2'd2, 8'h00, 1'b0);
        @(posedge clk);
        #1;
        check("R6 pre-reset write", 32'(wr_en), 32'd1);
        rst_n = 1'b0;
        #1;
        check("R7 async clear wr_en", 32'(wr_en), 32'd0);
        check("R7 async clear wr_addr", 32'(wr_addr), 32'd0);
        @(negedge clk);
        drive(1'b0, 1'b0, 7'h00, 2'd0, 8'h00, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule